// File: doc/BRIEF.md
# Serial Port Register Front End with Internal Loopback

This block is the bus-facing register file of one serial port channel. A processor reaches eleven 32-bit registers through a simple word-addressed port that has separate read and write strobes, each with its own address. Most of the registers only hold what was written: line format, FIFO setup, modem setup, error flags, FIFO fill and modem pins. Three of them have side effects on bus access: control, transmit holding and receive holding. Through these side effects the block drives the status word and two interrupt requests, one for each direction.

Either interrupt can run in one of two modes. In pulse mode it is a one-cycle strobe. In level mode it stays high until a clearing event. When the loopback control bit is set, a byte written for transmission lands straight in the receive holding register and is reported as received. No serial line is involved. A divisor register feeds a down-counter that makes a 16x bit-rate tick. The counter advances only on cycles when the selected clock enable is high, and a control bit picks one of two enables.

The register offsets are 0x00 line format, 0x04 control, 0x08 FIFO setup, 0x0C modem setup, 0x10 status, 0x14 error flags, 0x18 FIFO fill, 0x1C modem pins, 0x20 transmit holding, 0x24 receive holding and 0x28 divisor. The control bits are: 5 loopback, 8 receive interrupt level mode, 9 transmit interrupt level mode, 10 clock select. The status bits are: 0 receive ready, 1 transmit buffer empty, 2 transmitter empty.

Top module: `uart_regfile_lb`

## Requirements
- R1: After reset the status register reads 0x00000006 and every other register reads 0, and both interrupt outputs and the tick are low.
- R2: A read of the receive holding register (0x24) clears status bit 0. If control bit 8 is set, the same read also drops the receive interrupt.
- R3: A write to control (0x04) with data bit 9 set raises the transmit interrupt and holds it high. A write with data bit 8 set drops the receive interrupt. Neither write changes status bit 0.
- R4: A write to transmit holding (0x20) sets status bits 1 and 2. It raises the transmit interrupt in the same edge: the interrupt is held high when control bit 9 is set, and is a one-cycle strobe when bit 9 is clear.
- R5: With control bit 5 set, a transmit write also stores its data in receive holding and sets status bit 0. It raises the receive interrupt, held high when control bit 8 is set and as a one-cycle strobe when bit 8 is clear.
- R6: With control bit 5 clear, a transmit write leaves receive holding, status bit 0 and the receive interrupt unchanged.
- R7: The tick is a one-cycle strobe that repeats every D+1 enabled cycles, where D is bits 15:0 of the divisor register. Bits 31:16 are stored but do not affect the rate.
- R8: When control bit 10 is set, only cycles with uclk_en high advance the tick counter. When bit 10 is clear, only cycles with pclk_en high advance it.
- R9: A read from an offset that is not one of the eleven register offsets returns 0xFFFFFFFF. A write to such an offset changes nothing.
- R10: Read data appears on rd_data one cycle after rd_en and holds until the next read. It shows the register as it was before any write on the same edge.
- R11: If a receive holding read and a loopback transmit write fall on the same edge, the read returns the old byte. The write's effects win: status bit 0 ends set and the receive interrupt is raised.
- R12: The line format, FIFO setup, modem setup, error flag, FIFO fill, modem pin and divisor registers read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| pclk_en | input | 1 | Bus-side clock enable for the tick counter |
| uclk_en | input | 1 | External-clock enable for the tick counter |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| baud_tick | output | 1 | 16x bit-rate strobe |

## Verification
The read and write ports have separate addresses, so a read of receive holding can share an edge with a loopback transmit write. One wants to clear the receive-ready flag and the level interrupt, and the other wants to set them. The bench drives both strobes in the same cycle. It then checks four things: the returned byte is the old one, rx_irq is high, a status read shows bit 0 set, and a second receive read returns the new byte. A second overlap is also provoked: a control write with bit 8 set that lands while loopback data is pending. The bench checks that this write drops the interrupt but keeps the ready flag.

// File: rtl/uart_regfile_lb.sv
module uart_regfile_lb #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pclk_en,
  input  logic              uclk_en,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              baud_tick
);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_MODM = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_ERRS = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_FILL = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_TXB  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_RXB  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(8'h28);
  localparam int B_LOOP = 5;
  localparam int B_RXLV = 8;
  localparam int B_TXLV = 9;
  localparam int B_CSEL = 10;
  localparam logic [DATA_W-1:0] STAT_INIT = DATA_W'(6);

  logic [DATA_W-1:0] line_q, ctrl_q, fifo_q, modm_q, stat_q, errs_q;
  logic [DATA_W-1:0] fill_q, pins_q, txb_q, rxb_q, div_q;
  logic [DATA_W-1:0] stat_d, rxb_d, rd_mux;
  logic              tx_lvl, rx_lvl, tx_pls, rx_pls, rx_lvl_d, tx_lvl_d;
  logic [DIV_W-1:0]  cnt_q;

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire wr_txb  = wr_en && wr_addr == A_TXB;
  wire rd_rxb  = rd_en && rd_addr == A_RXB;
  wire loop_wr = wr_txb && ctrl_q[B_LOOP];
  wire cnt_en  = ctrl_q[B_CSEL] ? uclk_en : pclk_en;

  assign tx_irq = tx_lvl | tx_pls;
  assign rx_irq = rx_lvl | rx_pls;

  always_comb begin
    stat_d = stat_q;
    if (rd_rxb) stat_d[0] = 1'b0;
    if (wr_en && wr_addr == A_STAT) stat_d = wr_data;
    if (wr_txb) stat_d[2:1] = 2'b11;
    if (loop_wr) stat_d[0] = 1'b1;

    rxb_d = rxb_q;
    if (wr_en && wr_addr == A_RXB) rxb_d = wr_data;
    if (loop_wr) rxb_d = wr_data;

    rx_lvl_d = rx_lvl;
    if (rd_rxb && ctrl_q[B_RXLV]) rx_lvl_d = 1'b0;
    if (wr_ctrl && wr_data[B_RXLV]) rx_lvl_d = 1'b0;
    if (loop_wr && ctrl_q[B_RXLV]) rx_lvl_d = 1'b1;

    tx_lvl_d = tx_lvl;
    if (wr_ctrl && wr_data[B_TXLV]) tx_lvl_d = 1'b1;
    if (wr_txb && ctrl_q[B_TXLV]) tx_lvl_d = 1'b1;
  end

  always_comb begin
    case (rd_addr)
      A_LINE:  rd_mux = line_q;
      A_CTRL:  rd_mux = ctrl_q;
      A_FIFO:  rd_mux = fifo_q;
      A_MODM:  rd_mux = modm_q;
      A_STAT:  rd_mux = stat_q;
      A_ERRS:  rd_mux = errs_q;
      A_FILL:  rd_mux = fill_q;
      A_PINS:  rd_mux = pins_q;
      A_TXB:   rd_mux = txb_q;
      A_RXB:   rd_mux = rxb_q;
      A_DIV:   rd_mux = div_q;
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0; ctrl_q <= '0; fifo_q <= '0; modm_q <= '0;
      errs_q <= '0; fill_q <= '0; pins_q <= '0; txb_q  <= '0;
      div_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_LINE: line_q <= wr_data;
        A_CTRL: ctrl_q <= wr_data;
        A_FIFO: fifo_q <= wr_data;
        A_MODM: modm_q <= wr_data;
        A_ERRS: errs_q <= wr_data;
        A_FILL: fill_q <= wr_data;
        A_PINS: pins_q <= wr_data;
        A_TXB:  txb_q  <= wr_data;
        A_DIV:  div_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= STAT_INIT;
      rxb_q   <= '0;
      rd_data <= '0;
      tx_lvl  <= 1'b0;
      rx_lvl  <= 1'b0;
      tx_pls  <= 1'b0;
      rx_pls  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      rxb_q  <= rxb_d;
      tx_lvl <= tx_lvl_d;
      rx_lvl <= rx_lvl_d;
      tx_pls <= wr_txb && !ctrl_q[B_TXLV];
      rx_pls <= loop_wr && !ctrl_q[B_RXLV];
      if (rd_en) rd_data <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= cnt_en && cnt_q == '0;
      if (cnt_en) cnt_q <= (cnt_q == '0) ? div_q[DIV_W-1:0] : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_regfile_lb_chk.sv
module uart_regfile_lb_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              pclk_en,
  input logic              uclk_en,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              baud_tick
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_TXB  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_RXB  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(8'h28);

  logic [DATA_W-1:0] shadow;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shadow <= '0;
    else if (wr_en && wr_addr == A_CTRL) shadow <= wr_data;

  wire bad_rd   = rd_en && (rd_addr > A_LAST || rd_addr[1:0] != 2'b00);
  wire txb_wr   = wr_en && wr_addr == A_TXB;
  wire ctrl_wr  = wr_en && wr_addr == A_CTRL;
  wire rxb_rd   = rd_en && rd_addr == A_RXB;
  wire sel_en   = shadow[10] ? uclk_en : pclk_en;

  AST_BAD_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |=> rd_data == '1); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10
  AST_TXB_RAISES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    txb_wr |=> tx_irq); // R4
  AST_CTRL_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wr_data[9] |=> tx_irq); // R3
  AST_LOOP_RAISES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    txb_wr && shadow[5] |=> rx_irq); // R5
  AST_RXB_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_rd && shadow[8] && !(txb_wr && shadow[5]) && !ctrl_wr |=> !rx_irq); // R2
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_tick) |-> $past(sel_en)); // R8
endmodule

bind uart_regfile_lb uart_regfile_lb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pclk_en(pclk_en),
  .uclk_en(uclk_en), .tx_irq(tx_irq), .rx_irq(rx_irq), .baud_tick(baud_tick));

// File: tb/sim_uart_regfile_lb.sv
module sim_uart_regfile_lb;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0, pclk_en = 0, uclk_en = 0;
  logic [5:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, got;
  logic        tx_irq, rx_irq, baud_tick;
  logic        uclk_tog = 0, uclk_hold = 0;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  uart_regfile_lb u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .rd_data, .pclk_en, .uclk_en, .tx_irq, .rx_irq, .baud_tick);

  always @(negedge clk) uclk_en <= uclk_tog ? ~uclk_en : uclk_hold;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; pclk_en = 0; uclk_tog = 0; uclk_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0; d = rd_data;
  endtask

  task automatic tick_gap(output int gap);
    gap = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (baud_tick) break; end
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      if (baud_tick) begin gap = i; break; end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx_irq", 32'(tx_irq), 0);
    chk("R1 rx_irq", 32'(rx_irq), 0);
    chk("R1 tick", 32'(baud_tick), 0);
    for (int i = 0; i < 11; i++) begin
      rd(6'(i * 4), got);
      chk($sformatf("R1 reg %0h", i * 4), got, (i == 4) ? 32'h6 : 32'h0);
    end
  endtask

  task automatic t_storage();
    logic [5:0] offs [7] = '{6'h00, 6'h08, 6'h0C, 6'h14, 6'h18, 6'h1C, 6'h28};
    do_reset();
    foreach (offs[i]) wr(offs[i], 32'hA5C30000 + 32'(i) * 32'h01010101);
    foreach (offs[i]) begin
      rd(offs[i], got);
      chk("R12 readback", got, 32'hA5C30000 + 32'(i) * 32'h01010101);
    end
    wr(6'h00, 32'h11);
    wr_en = 1; wr_addr = 6'h00; wr_data = 32'h22; rd_en = 1; rd_addr = 6'h00;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R10 old value on same edge", rd_data, 32'h11);
    repeat (2) @(negedge clk);
    chk("R10 data held", rd_data, 32'h11);
    rd(6'h00, got);
    chk("R10 new value", got, 32'h22);
  endtask

  task automatic t_invalid();
    do_reset();
    rd(6'h2C, got); chk("R9 read 0x2C", got, 32'hFFFFFFFF);
    rd(6'h3C, got); chk("R9 read 0x3C", got, 32'hFFFFFFFF);
    rd(6'h05, got); chk("R9 read 0x05", got, 32'hFFFFFFFF);
    wr(6'h2C, 32'hDEAD0001);
    wr(6'h30, 32'hDEAD0002);
    wr(6'h07, 32'hDEAD0003);
    wr(6'h22, 32'hDEAD0004);
    chk("R9 no irq", {30'd0, tx_irq, rx_irq}, 0);
    for (int i = 0; i < 11; i++) begin
      rd(6'(i * 4), got);
      chk("R9 regs untouched", got, (i == 4) ? 32'h6 : 32'h0);
    end
  endtask

  task automatic t_tx_pulse();
    do_reset();
    wr(6'h10, 32'h0);
    wr(6'h20, 32'h41);
    chk("R4 pulse high", 32'(tx_irq), 1);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(tx_irq), 0);
    rd(6'h10, got); chk("R4/R6 status bits", got, 32'h6);
    rd(6'h24, got); chk("R6 rx holding untouched", got, 32'h0);
    chk("R6 no rx irq", 32'(rx_irq), 0);
  endtask

  task automatic t_tx_level();
    do_reset();
    wr(6'h04, 32'h200);
    chk("R3 ctrl raises tx", 32'(tx_irq), 1);
    repeat (3) @(negedge clk);
    chk("R3 tx held", 32'(tx_irq), 1);
    wr(6'h20, 32'h7E);
    repeat (3) @(negedge clk);
    chk("R4 level held after tx write", 32'(tx_irq), 1);
  endtask

  task automatic t_loop_pulse();
    do_reset();
    wr(6'h04, 32'h20);
    wr(6'h10, 32'h0);
    wr(6'h20, 32'h5A);
    chk("R5 rx strobe high", 32'(rx_irq), 1);
    @(negedge clk);
    chk("R5 rx strobe one cycle", 32'(rx_irq), 0);
    rd(6'h10, got); chk("R5 status ready", got, 32'h7);
    rd(6'h24, got); chk("R5 loop data", got, 32'h5A);
    rd(6'h10, got); chk("R2 read clears ready", got, 32'h6);
  endtask

  task automatic t_loop_level();
    do_reset();
    wr(6'h04, 32'h120);
    wr(6'h20, 32'h33);
    repeat (3) @(negedge clk);
    chk("R5 rx level held", 32'(rx_irq), 1);
    rd(6'h24, got);
    chk("R5 level loop data", got, 32'h33);
    chk("R2 read drops rx level", 32'(rx_irq), 0);
    wr(6'h20, 32'h44);
    chk("R5 rx level again", 32'(rx_irq), 1);
    wr(6'h04, 32'h120);
    chk("R3 ctrl bit8 drops rx", 32'(rx_irq), 0);
    rd(6'h10, got); chk("R3 ready kept", got, 32'h7);
  endtask

  task automatic t_same_edge();
    do_reset();
    wr(6'h04, 32'h120);
    wr(6'h20, 32'h10);
    wr_en = 1; wr_addr = 6'h20; wr_data = 32'h99; rd_en = 1; rd_addr = 6'h24;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R11 read returns old byte", rd_data, 32'h10);
    chk("R11 rx stays raised", 32'(rx_irq), 1);
    rd(6'h10, got); chk("R11 ready set", got, 32'h7);
    rd(6'h24, got); chk("R11 new byte", got, 32'h99);
  endtask

  task automatic t_baud();
    int gap;
    do_reset();
    pclk_en = 1;
    wr(6'h28, 32'h00050003);
    tick_gap(gap); chk("R7 period div 3", 32'(gap), 4);
    tick_gap(gap); chk("R7 tick one cycle", 32'(gap), 4);
    wr(6'h28, 32'h0);
    tick_gap(gap); tick_gap(gap);
    chk("R7 period div 0", 32'(gap), 1);
    wr(6'h28, 32'h3);
    uclk_tog = 1;
    wr(6'h04, 32'h400);
    tick_gap(gap); tick_gap(gap);
    chk("R8 external enable period", 32'(gap), 8);
    uclk_tog = 0; uclk_hold = 0;
    tick_gap(gap);
    chk("R8 no tick without external enable", 32'(gap), 0);
    wr(6'h04, 32'h0);
    pclk_en = 0; uclk_tog = 1;
    tick_gap(gap);
    chk("R8 no tick without bus enable", 32'(gap), 0);
    uclk_tog = 0;
  endtask

  initial begin
    t_reset();
    t_storage();
    t_invalid();
    t_tx_pulse();
    t_tx_level();
    t_loop_pulse();
    t_loop_level();
    t_same_edge();
    t_baud();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule